// File: doc/BRIEF.md
# Transmit Command FIFO with CRC Append

This block sits between a frame-building controller and a transmit serializer. Each clock cycle the controller presents a 16-bit data word and an 8-bit command vector whose bits are one-cycle pulses. The block turns the pulses into byte writes to an internal FIFO. It pushes one or two data bytes, and it keeps a running CRC-32 over the data bytes of the current frame. It can append the CRC in two halves, insert an error-marker byte, add a CRC-error marker byte, tag end of frame, and flush the FIFO.

Every FIFO entry holds a data byte, an end-of-frame tag and an error tag. The consumer reads the head entry through a plain valid/pop port. Several commands that must take effect together are set in the same vector. The block then writes all of their bytes in one cycle, in a fixed order. A sticky overrun flag and a sticky command-error flag report misuse. Only the flush command clears them.

Top module: `txcmd_crc_fifo`

## Requirements
- R1: The command vector bits are: bit 0 push-byte, bit 1 push-word, bit 2 CRC-high, bit 3 CRC-low, bit 4 error-marker, bit 5 end-of-frame, bit 6 flush, bit 7 CRC-error. Bits set together in one cycle act in that cycle. When push-byte and push-word are both set, only push-word acts.
- R2: Push-byte writes data[7:0] as one entry. Push-word writes data[7:0] and then data[15:0]'s upper byte data[15:8] as two entries. Pushes are accepted on consecutive cycles, and a push and a pop may occur in the same cycle.
- R3: The valid output is high whenever the FIFO holds an entry, and the head entry's byte and tags are shown on the outputs. A pop removes the head entry. A pop while the FIFO is empty has no effect.
- R4: The CRC is the reflected CRC-32 (polynomial 0x04C11DB7, start value all ones, final inversion), so the nine bytes "123456789" give 0xCBF43926. Bytes pushed in the same cycle as CRC-high are included. Accumulation restarts at the first push after end-of-frame or flush.
- R5: CRC-high stops accumulation and writes CRC[23:16] and then CRC[31:24]. CRC-low writes CRC[7:0] and then CRC[15:8].
- R6: The CRC-ready output rises exactly CRC_LAT (default 6) cycles after the CRC-high cycle. The CRC value output then holds the final CRC.
- R7: Bytes of one cycle are written in this order: data bytes, CRC-high bytes, CRC-low bytes, error-marker byte, CRC-error byte. End-of-frame tags the last byte written in its cycle. If no byte is written in that cycle, it tags the newest entry already stored.
- R8: The error-marker command writes a 0x00 entry with its error tag set.
- R9: CRC-error is legal only together with end-of-frame, optionally with error-marker as well, and no earlier than 3 cycles after the previous non-zero command vector. A legal CRC-error writes a 0xA5 entry with its error tag set, but only while CRC-ready is high. An illegal vector is ignored as a whole and sets the sticky command-error output.
- R10: A legal flush empties the FIFO, clears all entries, clears the overrun and command-error outputs and restarts the CRC. Every other bit set in the same vector is ignored.
- R11: The bytes of one cycle are written all together or not at all. If they do not fit, they are dropped and the overrun output is set. While overrun is set, every write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 8 | Command pulse vector |
| data_i | input | 16 | Data word for push commands |
| pop_i | input | 1 | Remove the head entry |
| q_valid_o | output | 1 | FIFO holds at least one entry |
| q_data_o | output | 8 | Head entry byte |
| q_eof_o | output | 1 | Head entry end-of-frame tag |
| q_err_o | output | 1 | Head entry error tag |
| fcs_ready_o | output | 1 | Final CRC is valid |
| fcs_value_o | output | 32 | Final CRC of the frame |
| overrun_o | output | 1 | Sticky overrun flag |
| cmd_error_o | output | 1 | Sticky illegal-command flag |

## Verification
Two functions can coincide in one cycle. The first is a data push landing together with CRC-high: the bench sends the ninth byte of "123456789" in the CRC-high vector and expects the known CRC-32 check value in both the CRC output and the appended bytes. The second is a push landing together with a pop: the bench pops the head while writing a new byte, then expects exactly the new byte at the head. A sweep that fills the FIFO word by word then shows that a two-byte write which no longer fits is dropped as a whole.

// File: rtl/txc_pkg.sv
package txc_pkg;

    localparam int CMD_W = 8;

    localparam int B_PUSH8   = 0;
    localparam int B_PUSH16  = 1;
    localparam int B_CRC_HI  = 2;
    localparam int B_CRC_LO  = 3;
    localparam int B_ERR_NIB = 4;
    localparam int B_EOF     = 5;
    localparam int B_FLUSH   = 6;
    localparam int B_CRC_ERR = 7;

    // Largest write set: word + crc high + crc low + error marker
    localparam int MAXW  = 7;
    localparam int CNT_W = $clog2(MAXW + 1);

    localparam logic [7:0]  MARK_ERR    = 8'h00;
    localparam logic [7:0]  MARK_CRCERR = 8'hA5;
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;

    typedef struct packed {
        logic [7:0] data;
        logic       eof;
        logic       err;
    } entry_t;

    typedef struct packed {
        logic push8;
        logic push16;
        logic crc_hi;
        logic crc_lo;
        logic err_nib;
        logic eof;
        logic flush;
        logic crc_err;
    } act_t;

    function automatic logic [31:0] crc32_byte(input logic [31:0] state, input logic [7:0] b);
        logic [31:0] s;
        logic        fb;
        s = state;
        for (int i = 0; i < 8; i++) begin
            fb = s[0] ^ b[i];
            s  = {1'b0, s[31:1]};
            if (fb) s = s ^ CRC_POLY_R;
        end
        return s;
    endfunction

endpackage

// File: rtl/txc_cmd_decode.sv
module txc_cmd_decode
    import txc_pkg::*;
#(
    parameter int MIN_GAP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] cmd_i,
    output act_t             act_o,
    output logic             illegal_o
);

    localparam int GW = $clog2(MIN_GAP + 1);
    localparam logic [CMD_W-1:0] CE_MASK = (CMD_W'(1) << B_CRC_ERR)
                                         | (CMD_W'(1) << B_EOF)
                                         | (CMD_W'(1) << B_ERR_NIB);

    logic [GW-1:0] gap_q;

    always_comb begin
        illegal_o = cmd_i[B_CRC_ERR]
                 && (!cmd_i[B_EOF]
                     || ((cmd_i & ~CE_MASK) != '0)
                     || (gap_q != GW'(MIN_GAP)));
        act_o = '0;
        if (!illegal_o) begin
            if (cmd_i[B_FLUSH]) begin
                act_o.flush = 1'b1;
            end else begin
                act_o.push16  = cmd_i[B_PUSH16];
                act_o.push8   = cmd_i[B_PUSH8] && !cmd_i[B_PUSH16];
                act_o.crc_hi  = cmd_i[B_CRC_HI];
                act_o.crc_lo  = cmd_i[B_CRC_LO];
                act_o.err_nib = cmd_i[B_ERR_NIB];
                act_o.eof     = cmd_i[B_EOF];
                act_o.crc_err = cmd_i[B_CRC_ERR];
            end
        end
    end

    // cycles since the last non-zero vector, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GW'(MIN_GAP);
        end else if (cmd_i != '0) begin
            gap_q <= GW'(1);
        end else if (gap_q != GW'(MIN_GAP)) begin
            gap_q <= gap_q + GW'(1);
        end
    end

endmodule

// File: rtl/txc_crc_unit.sv
module txc_crc_unit
    import txc_pkg::*;
#(
    parameter int CRC_LAT = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  act_t        act_i,
    input  logic [15:0] data_i,
    input  logic        wr_ok_i,
    output logic [31:0] fcs_now_o,
    output logic [31:0] fcs_q_o,
    output logic        fcs_ok_o
);

    localparam int LW = $clog2(CRC_LAT + 1);

    logic [31:0] crc_q, fcs_q;
    logic        restart_q, frozen_q;
    logic [LW-1:0] lat_q;

    logic        has_push, frame_new, eff_frozen;
    logic [31:0] base, step1, step2, crc_acc;

    always_comb begin
        has_push   = act_i.push8 || act_i.push16;
        frame_new  = restart_q && has_push && wr_ok_i;
        eff_frozen = frozen_q && !frame_new;
        base       = frame_new ? CRC_SEED : crc_q;
        step1      = crc32_byte(base, data_i[7:0]);
        step2      = crc32_byte(step1, data_i[15:8]);
        crc_acc    = crc_q;
        if (wr_ok_i && has_push && !eff_frozen) begin
            crc_acc = act_i.push16 ? step2 : step1;
        end
        fcs_now_o  = act_i.crc_hi ? ~crc_acc : fcs_q;
    end

    always_ff @(posedge clk) begin
        if (rst || act_i.flush) begin
            crc_q     <= CRC_SEED;
            fcs_q     <= '0;
            restart_q <= 1'b1;
            frozen_q  <= 1'b0;
            lat_q     <= '0;
        end else begin
            crc_q <= crc_acc;
            fcs_q <= fcs_now_o;
            if (act_i.eof)      restart_q <= 1'b1;
            else if (frame_new) restart_q <= 1'b0;
            if (act_i.crc_hi)   frozen_q <= 1'b1;
            else if (frame_new) frozen_q <= 1'b0;
            if (act_i.crc_hi)   lat_q <= LW'(CRC_LAT);
            else if (lat_q != '0) lat_q <= lat_q - LW'(1);
        end
    end

    assign fcs_q_o  = fcs_q;
    assign fcs_ok_o = frozen_q && (lat_q == '0);

endmodule

// File: rtl/txc_byte_fifo.sv
module txc_byte_fifo
    import txc_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic [CNT_W-1:0] wcount_i,
    input  entry_t           wdata_i [MAXW],
    input  logic             tag_last_i,
    input  logic             pop_i,
    output entry_t           head_o,
    output logic             valid_o,
    output logic             accept_o,
    output logic             overrun_o
);

    localparam int AW = $clog2(DEPTH);

    entry_t        mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count_q;
    logic          ovf_q;
    logic          pop_fire, fits;

    always_comb begin
        pop_fire = pop_i && (count_q != '0);
        fits     = (int'(count_q) - int'(pop_fire) + int'(wcount_i)) <= DEPTH;
        accept_o = (wcount_i != '0) && fits && !ovf_q;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (accept_o) begin
                for (int i = 0; i < MAXW; i++) begin
                    if (i < int'(wcount_i)) mem[wr_ptr + AW'(i)] <= wdata_i[i];
                end
            end else if (tag_last_i && count_q != '0) begin
                mem[wr_ptr - AW'(1)].eof <= 1'b1;
            end
            if (wcount_i != '0 && !fits) ovf_q <= 1'b1;
            wr_ptr  <= wr_ptr + (accept_o ? AW'(wcount_i) : AW'(0));
            rd_ptr  <= rd_ptr + AW'(pop_fire);
            count_q <= count_q + (accept_o ? (AW+1)'(wcount_i) : (AW+1)'(0))
                               - (AW+1)'(pop_fire);
        end
    end

    assign head_o    = mem[rd_ptr];
    assign valid_o   = (count_q != '0);
    assign overrun_o = ovf_q;

endmodule

// File: rtl/txcmd_crc_fifo.sv
module txcmd_crc_fifo
    import txc_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int CRC_LAT = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  cmd_i,
    input  logic [15:0] data_i,
    input  logic        pop_i,
    output logic        q_valid_o,
    output logic [7:0]  q_data_o,
    output logic        q_eof_o,
    output logic        q_err_o,
    output logic        fcs_ready_o,
    output logic [31:0] fcs_value_o,
    output logic        overrun_o,
    output logic        cmd_error_o
);

    act_t             act;
    logic             illegal;
    logic [CNT_W-1:0] wcount;
    entry_t           wdata [MAXW];
    entry_t           head;
    logic             accept, fcs_ok, tag_last, cmd_err_q;
    logic [31:0]      fcs_now, fcs_q;
    logic             act_crc_hi, act_flush;

    txc_cmd_decode #(.MIN_GAP(3)) u_dec (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .act_o(act), .illegal_o(illegal)
    );

    txc_crc_unit #(.CRC_LAT(CRC_LAT)) u_crc (
        .clk(clk), .rst(rst), .act_i(act), .data_i(data_i), .wr_ok_i(accept),
        .fcs_now_o(fcs_now), .fcs_q_o(fcs_q), .fcs_ok_o(fcs_ok)
    );

    // number of bytes this cycle; independent of byte values
    always_comb begin
        wcount = '0;
        if (act.push16)     wcount = CNT_W'(2);
        else if (act.push8) wcount = CNT_W'(1);
        if (act.crc_hi)  wcount = wcount + CNT_W'(2);
        if (act.crc_lo)  wcount = wcount + CNT_W'(2);
        if (act.err_nib) wcount = wcount + CNT_W'(1);
        if (act.crc_err && fcs_ok) wcount = wcount + CNT_W'(1);
        tag_last = act.eof && (wcount == '0);
    end

    // ordered byte list for this cycle
    always_comb begin
        int k;
        k = 0;
        for (int i = 0; i < MAXW; i++) wdata[i] = '0;
        if (act.push16) begin
            wdata[0].data = data_i[7:0];
            wdata[1].data = data_i[15:8];
            k = 2;
        end else if (act.push8) begin
            wdata[0].data = data_i[7:0];
            k = 1;
        end
        if (act.crc_hi) begin
            wdata[k].data   = fcs_now[23:16];
            wdata[k+1].data = fcs_now[31:24];
            k = k + 2;
        end
        if (act.crc_lo) begin
            wdata[k].data   = fcs_now[7:0];
            wdata[k+1].data = fcs_now[15:8];
            k = k + 2;
        end
        if (act.err_nib) begin
            wdata[k].data = MARK_ERR;
            wdata[k].err  = 1'b1;
            k = k + 1;
        end
        if (act.crc_err && fcs_ok) begin
            wdata[k].data = MARK_CRCERR;
            wdata[k].err  = 1'b1;
            k = k + 1;
        end
        if (act.eof && k > 0) wdata[k-1].eof = 1'b1;
    end

    txc_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush_i(act.flush), .wcount_i(wcount),
        .wdata_i(wdata), .tag_last_i(tag_last), .pop_i(pop_i),
        .head_o(head), .valid_o(q_valid_o), .accept_o(accept),
        .overrun_o(overrun_o)
    );

    always_ff @(posedge clk) begin
        if (rst || act.flush) cmd_err_q <= 1'b0;
        else if (illegal)     cmd_err_q <= 1'b1;
    end

    assign act_crc_hi  = act.crc_hi;
    assign act_flush   = act.flush;
    assign q_data_o    = head.data;
    assign q_eof_o     = head.eof;
    assign q_err_o     = head.err;
    assign fcs_ready_o = fcs_ok;
    assign fcs_value_o = fcs_q;
    assign cmd_error_o = cmd_err_q;

endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
    parameter int CRC_LAT = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       act_crc_hi,
    input logic       act_flush,
    input logic       illegal,
    input logic       pop_i,
    input logic       q_valid_o,
    input logic [7:0] q_data_o,
    input logic       q_err_o,
    input logic       fcs_ready_o,
    input logic       overrun_o,
    input logic       cmd_error_o
);

    localparam int SW = $clog2(CRC_LAT + 2);

    logic [SW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)                           since_q <= SW'(CRC_LAT + 1);
        else if (act_crc_hi)               since_q <= '0;
        else if (since_q <= SW'(CRC_LAT))  since_q <= since_q + SW'(1);
    end

    a_r6_not_ready_early: assert property (@(posedge clk) disable iff (rst)
        (since_q < SW'(CRC_LAT)) |-> !fcs_ready_o);

    a_r6_rise_on_time: assert property (@(posedge clk) disable iff (rst)
        $rose(fcs_ready_o) |-> (since_q == SW'(CRC_LAT)));

    a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !act_flush) |=> overrun_o);

    a_r9_cmd_error_sticky: assert property (@(posedge clk) disable iff (rst)
        (cmd_error_o && !act_flush) |=> cmd_error_o);

    a_r9_illegal_flags: assert property (@(posedge clk) disable iff (rst)
        illegal |=> cmd_error_o);

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        act_flush |=> (!q_valid_o && !overrun_o && !cmd_error_o));

    a_r3_head_holds: assert property (@(posedge clk) disable iff (rst)
        (q_valid_o && !pop_i && !act_flush) |=>
            (q_valid_o && $stable(q_data_o) && $stable(q_err_o)));

endmodule

bind txcmd_crc_fifo txc_checker #(.CRC_LAT(CRC_LAT)) u_chk (
    .clk(clk), .rst(rst), .act_crc_hi(act_crc_hi), .act_flush(act_flush),
    .illegal(illegal), .pop_i(pop_i), .q_valid_o(q_valid_o),
    .q_data_o(q_data_o), .q_err_o(q_err_o), .fcs_ready_o(fcs_ready_o),
    .overrun_o(overrun_o), .cmd_error_o(cmd_error_o)
);

// File: tb/txcmd_crc_fifo_bench.sv
`timescale 1ns/1ps
module txcmd_crc_fifo_bench;

    localparam logic [7:0] P8 = 8'h01, P16 = 8'h02, HI = 8'h04, LO = 8'h08;
    localparam logic [7:0] EN = 8'h10, EF = 8'h20, FL = 8'h40, CE = 8'h80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cmd = '0;
    logic [15:0] data = '0;
    logic        pop = 1'b0;
    logic        q_valid, q_eof, q_err, fcs_ready, overrun, cmd_error;
    logic [7:0]  q_data;
    logic [31:0] fcs_value;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    txcmd_crc_fifo u_txcmd_crc_fifo (
        .clk(clk), .rst(rst), .cmd_i(cmd), .data_i(data), .pop_i(pop),
        .q_valid_o(q_valid), .q_data_o(q_data), .q_eof_o(q_eof), .q_err_o(q_err),
        .fcs_ready_o(fcs_ready), .fcs_value_o(fcs_value),
        .overrun_o(overrun), .cmd_error_o(cmd_error)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) r = (r >> 1) ^ (r[0] ? 32'hEDB88320 : 32'h0);
        return r;
    endfunction

    task automatic eq(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cmd1(input logic [7:0] c, input logic [15:0] d);
        cmd = c; data = d;
        @(negedge clk);
        cmd = '0; data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_exp(input string req, input logic [7:0] b, input logic e,
                           input logic r);
        eq(req, "valid", q_valid, 1'b1);
        eq(req, "byte", q_data, b);
        eq(req, "eof tag", q_eof, e);
        eq(req, "err tag", q_err, r);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] f;
        logic [7:0]  msg [9];
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        eq("R3", "valid after reset", q_valid, 1'b0);
        eq("R11", "overrun after reset", overrun, 1'b0);
        eq("R9", "cmd_error after reset", cmd_error, 1'b0);
        eq("R6", "ready after reset", fcs_ready, 1'b0);

        // R2/R4: back-to-back word pushes, last byte with CRC-high
        cmd1(P16, 16'h3231); cmd1(P16, 16'h3433);
        cmd1(P16, 16'h3635); cmd1(P16, 16'h3837);
        cmd1(P8 | HI, 16'h0039);
        eq("R6", "ready right after crc-high", fcs_ready, 1'b0);
        for (int i = 1; i < 6; i++) begin
            @(negedge clk);
            eq("R6", "ready before latency", fcs_ready, 1'b0);
        end
        @(negedge clk);
        eq("R6", "ready at latency", fcs_ready, 1'b1);
        eq("R4", "check value", fcs_value, 32'hCBF43926);
        cmd1(LO | EF, 16'h0);
        for (int i = 0; i < 9; i++) pop_exp("R2", msg[i], 1'b0, 1'b0);
        pop_exp("R5", 8'hF4, 1'b0, 1'b0);
        pop_exp("R5", 8'hCB, 1'b0, 1'b0);
        pop_exp("R5", 8'h26, 1'b0, 1'b0);
        pop_exp("R7", 8'h39, 1'b1, 1'b0);
        eq("R3", "empty after frame", q_valid, 1'b0);
        pop = 1'b1; @(negedge clk); pop = 1'b0;
        eq("R3", "pop on empty", q_valid, 1'b0);

        // R2: push together with pop; R4 restart after end-of-frame
        cmd1(P8, 16'h0011);
        cmd = P8; data = 16'h0022; pop = 1'b1;
        eq("R2", "head before push+pop", q_data, 8'h11);
        @(negedge clk);
        cmd = '0; data = '0; pop = 1'b0;
        pop_exp("R2", 8'h22, 1'b0, 1'b0);
        eq("R3", "single entry left", q_valid, 1'b0);
        cmd1(HI, 16'h0);
        idle(6);
        f = ~ref_crc(ref_crc(32'hFFFFFFFF, 8'h11), 8'h22);
        eq("R4", "restarted crc", fcs_value, f);
        pop_exp("R5", f[23:16], 1'b0, 1'b0);
        pop_exp("R5", f[31:24], 1'b0, 1'b0);

        // R8/R9: error marker and crc-error marker after full crc
        cmd1(EF, 16'h0);
        eq("R7", "eof on empty fifo", q_valid, 1'b0);
        cmd1(P8, 16'h0041);
        cmd1(HI, 16'h0);
        idle(6);
        cmd1(LO, 16'h0);
        idle(2);
        cmd1(EF | EN | CE, 16'h0);
        eq("R9", "legal crc-error", cmd_error, 1'b0);
        f = ~ref_crc(32'hFFFFFFFF, 8'h41);
        pop_exp("R4", 8'h41, 1'b0, 1'b0);
        pop_exp("R5", f[23:16], 1'b0, 1'b0);
        pop_exp("R5", f[31:24], 1'b0, 1'b0);
        pop_exp("R5", f[7:0], 1'b0, 1'b0);
        pop_exp("R5", f[15:8], 1'b0, 1'b0);
        pop_exp("R8", 8'h00, 1'b0, 1'b1);
        pop_exp("R9", 8'hA5, 1'b1, 1'b1);

        // R9: crc-error too soon; R7 eof tags stored entry
        cmd1(P8, 16'h0055);
        cmd1(HI, 16'h0);
        idle(6);
        cmd1(EF, 16'h0);
        idle(1);
        cmd1(EF | CE, 16'h0);
        eq("R9", "too-soon flagged", cmd_error, 1'b1);
        f = ~ref_crc(32'hFFFFFFFF, 8'h55);
        pop_exp("R7", 8'h55, 1'b0, 1'b0);
        pop_exp("R7", f[23:16], 1'b0, 1'b0);
        pop_exp("R7", f[31:24], 1'b1, 1'b0);
        eq("R9", "no marker when too soon", q_valid, 1'b0);
        cmd1(FL, 16'h0);
        eq("R10", "flush clears cmd_error", cmd_error, 1'b0);

        // R9: illegal combination ignored whole
        idle(3);
        cmd1(P8 | EF | CE, 16'h0077);
        eq("R9", "illegal push dropped", q_valid, 1'b0);
        eq("R9", "illegal combo flagged", cmd_error, 1'b1);
        cmd1(FL, 16'h0);

        // R9: legal crc-error while crc not ready
        cmd1(P8, 16'h0066);
        idle(3);
        eq("R6", "not ready in new frame", fcs_ready, 1'b0);
        cmd1(EF | CE, 16'h0);
        eq("R9", "legal not flagged", cmd_error, 1'b0);
        pop_exp("R9", 8'h66, 1'b1, 1'b0);
        eq("R9", "no marker when not ready", q_valid, 1'b0);

        // R11: fill sweep and all-or-nothing overrun
        cmd1(FL, 16'h0);
        for (int k = 0; k < 7; k++) cmd1(P16, {8'(2 * k + 1), 8'(2 * k)});
        cmd1(P8, 16'h000E);
        eq("R11", "no overrun at 15", overrun, 1'b0);
        cmd1(P16, 16'h100F);
        eq("R11", "overrun on word", overrun, 1'b1);
        for (int i = 0; i < 15; i++) pop_exp("R11", 8'(i), 1'b0, 1'b0);
        eq("R11", "partial word dropped", q_valid, 1'b0);
        cmd1(P8, 16'h0099);
        eq("R11", "dropped while overrun", q_valid, 1'b0);
        cmd1(FL, 16'h0);
        eq("R10", "flush clears overrun", overrun, 1'b0);

        // R10: flush wins over same-vector push
        cmd1(P8, 16'h0001); cmd1(P8, 16'h0002); cmd1(P8, 16'h0003);
        eq("R10", "filled before flush", q_valid, 1'b1);
        cmd1(FL | P8, 16'h0044);
        eq("R10", "flush empties", q_valid, 1'b0);
        idle(1);
        eq("R10", "still empty", q_valid, 1'b0);

        // R1: word wins over byte
        cmd1(P8 | P16, 16'hBBAA);
        pop_exp("R1", 8'hAA, 1'b0, 1'b0);
        pop_exp("R1", 8'hBB, 1'b0, 1'b0);
        eq("R1", "only two entries", q_valid, 1'b0);

        finish_run();
    end

endmodule